// File: doc/BRIEF.md
# Registered DDR2 Command Buffer with Late Parity Check

The block sits on a DDR2 memory module between the controller and the DRAM devices. It captures the 14-bit command and address bus on each rising clock edge and drives every captured bit onto two identical output copies, A and B, so that each copy can feed its own half of the device load. The command and address copies only take new values in cycles where one of the two chip selects is active (low). The clock-enable and on-die-termination lines, and the chip selects themselves, are registered and re-driven every cycle.

The controller sends an odd-parity bit for each command one cycle after the command itself. The block holds the command data for one pipeline stage so that it lines up with that late bit, checks the 15 bits together, and reports a failure on an active-low error flag that is delayed and stretched to two cycles. A partial parity output gives the XOR of the command's data bits. A slot-select input chooses whether the block acts as the first or the second register of a pair; in the second role the partial parity output also folds in the received parity bit. An active-low asynchronous reset clears everything.

Top module: `ddr_cmd_regbuf`

## Requirements
- R1: After a rising edge at which at least one bit of cs_n_i is 0, qa_o and qb_o both equal the data_i value sampled at that edge.
- R2: After a rising edge at which cs_n_i is 2'b11, qa_o and qb_o keep the values they had before that edge.
- R3: After every rising edge, qcke_a_o and qcke_b_o equal the sampled cke_i, and qodt_a_o and qodt_b_o equal the sampled odt_i, whatever the chip selects are.
- R4: After every rising edge, qcs_a_o and qcs_b_o equal the sampled cs_n_i (bit 0 to bit 0, bit 1 to bit 1).
- R5: par_i is sampled at the rising edge that follows a command edge (an edge with a cs_n_i bit at 0); a parity error is detected when the XOR of that command's 14 data bits and par_i is 0. par_i at an edge that does not follow a command edge has no effect on par_err_no.
- R6: With slot_sel_i low at the parity sample edge, part_par_o after that edge equals the XOR of the command's 14 data bits; part_par_o is unchanged after edges that are not parity sample edges.
- R7: par_err_no is 1 when idle; for an error detected at sample edge s it is 0 after edges s+2 and s+3 and returns to 1 after edge s+4 unless another error restarts it.
- R8: While rst_ni is 0, all outputs are 0 except par_err_no, which is 1, independent of the clock; a command captured before reset is discarded and produces no parity check after release.
- R9: With slot_sel_i high at the parity sample edge, part_par_o after that edge equals the XOR of the command's 14 data bits and par_i.
- R10: An error detected at sample edge s+1 while the flag is low from edge s restarts the window, so par_err_no stays 0 after edges s+2 through s+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_sel_i | input | 1 | Register role: 0 first, 1 second of a pair |
| data_i | input | 14 | Command and address bits |
| cs_n_i | input | 2 | Chip selects, active low |
| cke_i | input | 1 | Clock enable, ungated |
| odt_i | input | 1 | On-die termination, ungated |
| par_i | input | 1 | Odd parity bit, one cycle after its command |
| qa_o | output | 14 | Registered command copy A |
| qb_o | output | 14 | Registered command copy B |
| qcs_a_o | output | 2 | Registered chip selects, copy A |
| qcs_b_o | output | 2 | Registered chip selects, copy B |
| qcke_a_o | output | 1 | Registered clock enable, copy A |
| qcke_b_o | output | 1 | Registered clock enable, copy B |
| qodt_a_o | output | 1 | Registered termination, copy A |
| qodt_b_o | output | 1 | Registered termination, copy B |
| part_par_o | output | 1 | Partial parity of the last checked command |
| par_err_no | output | 1 | Parity error flag, active low, two cycles wide |

## Verification
Back-to-back commands are the main hazard: a design that checked the parity bit against the current data instead of the one-cycle-old command would flag good commands and miss bad ones. Idle cycles carrying a deliberately wrong parity bit catch a checker that does not qualify the sample with the previous chip select, and idle cycles with changing data catch outputs that are not gated. Two consecutive bad commands show whether the flag window restarts or drops back after two cycles, and a reset dropped into a live error pulse, with a command still pending, catches a flag or pipeline that survives reset.

// File: rtl/ddr_cmd_regbuf_pkg.sv
package ddr_cmd_regbuf_pkg;
  localparam int unsigned CMD_W    = 14;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned N_COPY   = 2;
  localparam int unsigned ERR_LAG  = 2;  // edges from parity sample to flag low
  localparam int unsigned ERR_HOLD = 2;  // cycles the flag stays low

  typedef struct packed {
    logic             cke;
    logic             odt;
    logic [SEL_W-1:0] cs_n;
  } ctrl_t;
endpackage

// File: rtl/ddr_cmd_out_stage.sv
module ddr_cmd_out_stage
  import ddr_cmd_regbuf_pkg::*;
#(
  parameter int unsigned DATA_W = CMD_W,
  parameter int unsigned NCOPY  = N_COPY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  ctrl_t             ctrl_i,
  output logic [DATA_W-1:0] data_o [NCOPY],
  output ctrl_t             ctrl_o [NCOPY]
);
  logic [DATA_W-1:0] data_q;
  ctrl_t             ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_i;
      if (load_i) data_q <= data_i;
    end
  end

  for (genvar g = 0; g < NCOPY; g++) begin : g_copy
    assign data_o[g] = data_q;
    assign ctrl_o[g] = ctrl_q;
  end
endmodule

// File: rtl/ddr_par_check.sv
module ddr_par_check
  import ddr_cmd_regbuf_pkg::*;
#(
  parameter int unsigned DATA_W = CMD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              sel2_i,
  output logic              hit_o,
  output logic              part_o
);
  logic              vld_q;
  logic [DATA_W-1:0] data_q;
  logic              hit_q;
  logic              part_q;
  logic              data_x;

  assign data_x = ^data_q;

  // stage 1 holds the command, stage 2 meets the late parity bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      hit_q  <= 1'b0;
      part_q <= 1'b0;
    end else begin
      vld_q  <= cmd_i;
      data_q <= data_i;
      hit_q  <= vld_q & ~(data_x ^ par_i);
      if (vld_q) part_q <= data_x ^ (sel2_i & par_i);
    end
  end

  assign hit_o  = hit_q;
  assign part_o = part_q;
endmodule

// File: rtl/ddr_err_stretch.sv
module ddr_err_stretch
  import ddr_cmd_regbuf_pkg::*;
#(
  parameter int unsigned LAG  = ERR_LAG,
  parameter int unsigned HOLD = ERR_HOLD
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic err_no
);
  localparam int unsigned DW    = (LAG > 1) ? LAG - 1 : 1;
  localparam int unsigned CNT_W = $clog2(HOLD + 1);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD);

  logic [DW-1:0]    dly_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
      cnt_q <= '0;
    end else begin
      dly_q[0] <= hit_i;
      for (int i = 1; i < DW; i++) dly_q[i] <= dly_q[i-1];
      // a fresh hit restarts the window
      if (dly_q[DW-1])       cnt_q <= HOLD_V;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign err_no = (cnt_q == '0);
endmodule

// File: rtl/ddr_cmd_regbuf.sv
module ddr_cmd_regbuf
  import ddr_cmd_regbuf_pkg::*;
#(
  parameter int unsigned DATA_W     = CMD_W,
  parameter int unsigned ERR_LAG_P  = ERR_LAG,
  parameter int unsigned ERR_HOLD_P = ERR_HOLD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SEL_W-1:0]  cs_n_i,
  input  logic              cke_i,
  input  logic              odt_i,
  input  logic              par_i,
  output logic [DATA_W-1:0] qa_o,
  output logic [DATA_W-1:0] qb_o,
  output logic [SEL_W-1:0]  qcs_a_o,
  output logic [SEL_W-1:0]  qcs_b_o,
  output logic              qcke_a_o,
  output logic              qcke_b_o,
  output logic              qodt_a_o,
  output logic              qodt_b_o,
  output logic              part_par_o,
  output logic              par_err_no
);
  logic              cmd_act;
  ctrl_t             ctrl_in;
  logic [DATA_W-1:0] data_cp [N_COPY];
  ctrl_t             ctrl_cp [N_COPY];
  logic              hit;

  assign cmd_act = ~&cs_n_i;
  assign ctrl_in = '{cke: cke_i, odt: odt_i, cs_n: cs_n_i};

  ddr_cmd_out_stage #(.DATA_W(DATA_W), .NCOPY(N_COPY)) i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cmd_act),
    .data_i (data_i),
    .ctrl_i (ctrl_in),
    .data_o (data_cp),
    .ctrl_o (ctrl_cp)
  );

  ddr_par_check #(.DATA_W(DATA_W)) i_par (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd_act),
    .data_i (data_i),
    .par_i  (par_i),
    .sel2_i (slot_sel_i),
    .hit_o  (hit),
    .part_o (part_par_o)
  );

  ddr_err_stretch #(.LAG(ERR_LAG_P), .HOLD(ERR_HOLD_P)) i_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .err_no (par_err_no)
  );

  assign qa_o     = data_cp[0];
  assign qb_o     = data_cp[1];
  assign qcs_a_o  = ctrl_cp[0].cs_n;
  assign qcs_b_o  = ctrl_cp[1].cs_n;
  assign qcke_a_o = ctrl_cp[0].cke;
  assign qcke_b_o = ctrl_cp[1].cke;
  assign qodt_a_o = ctrl_cp[0].odt;
  assign qodt_b_o = ctrl_cp[1].odt;
endmodule

// File: rtl/ddr_cmd_regbuf_chk.sv
module ddr_cmd_regbuf_chk #(
  parameter int unsigned DATA_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_i,
  input logic [1:0]        cs_n_i,
  input logic              cke_i,
  input logic              odt_i,
  input logic [DATA_W-1:0] qa_o,
  input logic [DATA_W-1:0] qb_o,
  input logic [1:0]        qcs_a_o,
  input logic [1:0]        qcs_b_o,
  input logic              qcke_a_o,
  input logic              qcke_b_o,
  input logic              qodt_a_o,
  input logic              qodt_b_o,
  input logic              par_err_no
);
  logic [2:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 3'd4)   age_q <= age_q + 3'd1;
  end

  AST_GATED_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni || age_q == 3'd0)
    !(&cs_n_i) |=> (qa_o == $past(data_i)) && (qb_o == $past(data_i))); // R1
  AST_GATED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || age_q == 3'd0)
    (&cs_n_i) |=> $stable(qa_o) && $stable(qb_o)); // R2
  AST_UNGATED_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni || age_q == 3'd0)
    rst_ni |=> (qcke_a_o == $past(cke_i)) && (qcke_b_o == $past(cke_i)) &&
               (qodt_a_o == $past(odt_i)) && (qodt_b_o == $past(odt_i))); // R3
  AST_CS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni || age_q == 3'd0)
    rst_ni |=> (qcs_a_o == $past(cs_n_i)) && (qcs_b_o == $past(cs_n_i))); // R4
  AST_ERR_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni || age_q != 3'd4)
    $fell(par_err_no) |-> $past(!(&cs_n_i), 4)); // R5
  AST_ERR_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(par_err_no) |=> !par_err_no); // R7
  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |-> par_err_no && (qa_o == '0) && (qb_o == '0) && (qcs_a_o == '0) &&
                !qcke_a_o && !qodt_b_o); // R8
endmodule

bind ddr_cmd_regbuf ddr_cmd_regbuf_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_ddr_cmd_regbuf.sv
module test_ddr_cmd_regbuf;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        slot_sel_i = 1'b0;
  logic [13:0] data_i = '0;
  logic [1:0]  cs_n_i = 2'b11;
  logic        cke_i = 1'b0;
  logic        odt_i = 1'b0;
  logic        par_i = 1'b0;
  logic [13:0] qa_o, qb_o;
  logic [1:0]  qcs_a_o, qcs_b_o;
  logic        qcke_a_o, qcke_b_o, qodt_a_o, qodt_b_o;
  logic        part_par_o, par_err_no;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ddr_cmd_regbuf i_ddr_cmd_regbuf (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  // model state, from the requirements
  logic [13:0] m_q, m_pend_d;
  logic [1:0]  m_cs;
  logic        m_cke, m_odt, m_ppo, m_pend_vld;
  logic [3:0]  m_hist;

  // {cs_n[1:0], data[13:0], bad_par, cke, odt}
  localparam logic [18:0] VEC [0:19] = '{
    {2'b10, 14'h1234, 1'b0, 1'b1, 1'b0},
    {2'b11, 14'h3fff, 1'b0, 1'b1, 1'b1},
    {2'b01, 14'h0aa5, 1'b0, 1'b0, 1'b1},
    {2'b00, 14'h2001, 1'b1, 1'b0, 1'b0},
    {2'b10, 14'h0f0f, 1'b0, 1'b1, 1'b0},
    {2'b11, 14'h1555, 1'b1, 1'b1, 1'b1},
    {2'b11, 14'h2aaa, 1'b1, 1'b0, 1'b1},
    {2'b11, 14'h0000, 1'b0, 1'b0, 1'b0},
    {2'b11, 14'h0000, 1'b0, 1'b1, 1'b0},
    {2'b10, 14'h3ffe, 1'b0, 1'b0, 1'b1},
    {2'b01, 14'h0001, 1'b1, 1'b1, 1'b1},
    {2'b11, 14'h0000, 1'b1, 1'b0, 1'b0},
    {2'b11, 14'h0000, 1'b0, 1'b0, 1'b1},
    {2'b11, 14'h0000, 1'b0, 1'b1, 1'b1},
    {2'b11, 14'h0000, 1'b0, 1'b0, 1'b0},
    {2'b00, 14'h1fff, 1'b0, 1'b1, 1'b0},
    {2'b11, 14'h0000, 1'b0, 1'b0, 1'b0},
    {2'b10, 14'h0000, 1'b1, 1'b1, 1'b0},
    {2'b11, 14'h0000, 1'b1, 1'b0, 1'b0},
    {2'b11, 14'h0000, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_q = '0; m_pend_d = '0; m_cs = '0; m_cke = 0; m_odt = 0;
    m_ppo = 0; m_pend_vld = 0; m_hist = '0;
  endtask

  task automatic chk_all(input string ptag);
    chk("R1 R2 qa", {18'd0, qa_o}, {18'd0, m_q});
    chk("R1 R2 qb", {18'd0, qb_o}, {18'd0, m_q});
    chk("R3 cke/odt", {28'd0, qcke_a_o, qcke_b_o, qodt_a_o, qodt_b_o},
        {28'd0, m_cke, m_cke, m_odt, m_odt});
    chk("R4 cs", {28'd0, qcs_a_o, qcs_b_o}, {28'd0, m_cs, m_cs});
    chk(ptag, {31'd0, part_par_o}, {31'd0, m_ppo});
    chk("R5 R7 R10 err", {31'd0, par_err_no}, {31'd0, !(m_hist[2] | m_hist[3])});
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic step(input logic [1:0] cs, input logic [13:0] d, input logic bad,
                      input logic ke, input logic ot);
    logic p, det;
    p = m_pend_vld ? ((~^m_pend_d) ^ bad) : bad;
    cs_n_i = cs; data_i = d; par_i = p; cke_i = ke; odt_i = ot;
    @(posedge clk_i);
    #1;
    det = m_pend_vld && ((^m_pend_d ^ p) == 1'b0);
    if (m_pend_vld) m_ppo = (^m_pend_d) ^ (slot_sel_i & p);
    m_hist = {m_hist[2:0], det};
    if (!(&cs)) m_q = d;
    m_cs = cs; m_cke = ke; m_odt = ot;
    m_pend_vld = !(&cs); m_pend_d = d;
    @(negedge clk_i);
    chk_all(slot_sel_i ? "R9 part" : "R6 part");
  endtask

  task automatic reset_mid();
    #3 rst_ni = 1'b0;
    #2;
    chk("R8 reset flag", {31'd0, par_err_no}, 32'd1);
    chk("R8 reset data", {18'd0, qa_o | qb_o}, 32'd0);
    chk("R8 reset ctrl", {25'd0, qcs_a_o, qcs_b_o, qcke_a_o, qcke_b_o, qodt_a_o, part_par_o},
        32'd0);
    model_clear();
    cs_n_i = 2'b11;
    @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R8 initial flag", {31'd0, par_err_no}, 32'd1);
    chk("R8 initial data", {18'd0, qa_o | qb_o}, 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < 20; i++) begin
      logic [18:0] v;
      v = VEC[i];
      step(v[18:17], v[16:3], v[2], v[1], v[0]);
    end
    repeat (3) step(2'b11, 14'h0000, 1'b0, 1'b0, 1'b0);

    // second-register role: partial parity folds in par_i (R9)
    slot_sel_i = 1'b1;
    step(2'b10, 14'h0003, 1'b0, 1'b0, 1'b0);
    step(2'b11, 14'h0000, 1'b0, 1'b0, 1'b0);
    chk("R9 part with par", {31'd0, part_par_o}, 32'd1);
    slot_sel_i = 1'b0;
    step(2'b10, 14'h0003, 1'b0, 1'b0, 1'b0);
    step(2'b11, 14'h0000, 1'b0, 1'b0, 1'b0);
    chk("R6 part data only", {31'd0, part_par_o}, 32'd0);

    // reset in the middle of an error pulse, with a command pending (R8)
    step(2'b01, 14'h0007, 1'b0, 1'b1, 1'b1);
    step(2'b11, 14'h0000, 1'b1, 1'b1, 1'b1);
    step(2'b11, 14'h0000, 1'b0, 1'b0, 1'b0);
    step(2'b10, 14'h2222, 1'b0, 1'b1, 1'b0);
    chk("R7 flag low before reset", {31'd0, par_err_no}, 32'd0);
    reset_mid();
    par_i = 1'b0;  // wrong for the discarded command
    repeat (5) step(2'b11, 14'h0000, 1'b1, 1'b0, 1'b0);
    chk("R8 no stale error", {31'd0, par_err_no}, 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule